// File: doc/BRIEF.md
# Multi-Channel Reloadable Down-Counter Timer

This block holds several independent 32-bit down-counters behind a single-cycle register port. Each channel counts one step down on every tick of its own prescaler, which divides the one input clock by 4, 16, 64 or 256. When a channel reaches zero, the next tick loads the reload constant into the counter and latches an underflow flag. The flag drives that channel's interrupt line if the channel's interrupt enable is set.

A single start register holds one run bit per channel. Software sets and clears those bits with read-modify-write. For a periodic event, the constant and the counter are both loaded with the period. For a one-shot delay, the counter gets the delay and the constant gets all ones. A free-running time base is the bitwise inverse of a counter whose constant is all ones.

Top module: `tick_timer_unit`

## Requirements
- R1: After reset, the start register reads 0, every constant and counter register reads 0xFFFFFFFF, every control register reads 0, and all interrupt lines are low.
- R2: Addresses are byte offsets on 32-bit words. The start register is at offset 0x00, and its bit n runs (1) or stops (0) channel n. Channel n uses three words from offset 4 + 12·n: the reload constant first, then the counter at +4, then the control register at +8. Every register reads back what was written to its defined bits.
- R3: A running channel's counter decreases by one once every D input clocks. D is chosen by control bits [2:0]: 000 gives 4, 001 gives 16, 010 gives 64, 011 gives 256, and any other code gives 4. The first decrement lands D clock edges after the edge that writes its run bit to 1.
- R4: A tick that finds the counter at 0 loads the counter with the reload constant. In the same update it sets the underflow flag, which reads at control bit 8.
- R5: Each channel's interrupt line is high exactly when its underflow flag and its interrupt-enable bit (control bit 5) are both 1.
- R6: A control write with bit 8 at 0 clears the underflow flag. A control write with bit 8 at 1 leaves the flag unchanged. The prescaler code and the enable bit take the written values in both cases.
- R7: Clearing a run bit freezes the channel's counter and restarts its prescaler phase. Setting the run bit again resumes counting from the held value, with a full D-clock wait before the first decrement.
- R8: A write to a counter takes effect on the next clock even while the channel runs. It overrides a decrement that falls on the same edge, and the prescaler phase is not disturbed.
- R9: Any offset that is not a multiple of 4, or that lies beyond the last channel's control register, reads 0 and ignores writes.
- R10: Channels running at the same time count independently, each at its own division ratio.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer and register clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 6 | Byte offset of the register accessed |
| wr_en | input | 1 | Write strobe, sampled on the rising clock edge |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq | output | 3 | Per-channel underflow interrupt |

## Verification
A wrong prescaler phase shows up as a counter value one step off after a run segment, and it shows within a single divide period. The bench therefore stops each channel after a chosen number of edges, including segments that end exactly on a tick edge, and compares the frozen counter with the arithmetic model. A missed or extra reload changes the counter value, the flag bit and the interrupt line on the edge after the zero count, so every sweep point compares all three. A decode error moves a write into a neighbouring register, and the readback of every channel and every unmapped offset exposes it at once.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  // control register field positions
  localparam int unsigned CTRL_PSEL_LSB = 0;
  localparam int unsigned CTRL_PSEL_W   = 3;
  localparam int unsigned CTRL_IE_BIT   = 5;
  localparam int unsigned CTRL_UF_BIT   = 8;
  localparam int unsigned PHASE_W       = 8;

  // last phase value of the prescaler for a select code (divide minus one)
  function automatic logic [PHASE_W-1:0] tmr_div_last(input logic [CTRL_PSEL_W-1:0] code);
    case (code)
      3'd1:    return 8'd15;
      3'd2:    return 8'd63;
      3'd3:    return 8'd255;
      default: return 8'd3;
    endcase
  endfunction
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import tmr_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   run,
  input  logic [CTRL_PSEL_W-1:0] psel,
  output logic                   tick
);
  logic [PHASE_W-1:0] phase_q;
  logic [PHASE_W-1:0] last;

  assign last = tmr_div_last(psel);
  assign tick = run && (phase_q >= last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       phase_q <= '0;
    else if (!run)    phase_q <= '0;
    else if (tick)    phase_q <= '0;
    else              phase_q <= phase_q + 1'b1;
  end

  // R7
  stopped_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !tick);
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              wr_const,
  input  logic              wr_count,
  input  logic              wr_ctrl,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] const_q,
  output logic [DATA_W-1:0] count_q,
  output logic [DATA_W-1:0] ctrl_rd,
  output logic              irq
);
  logic [CTRL_PSEL_W-1:0] psel_q;
  logic                   ie_q;
  logic                   uf_q;
  logic                   tick;
  logic                   underflow;
  logic                   flag_clear;
  logic [DATA_W-1:0]      count_nxt;

  // next counter value on a tick: step down, or reload at zero
  function automatic logic [DATA_W-1:0] step_count(input logic [DATA_W-1:0] cur,
                                                   input logic [DATA_W-1:0] rel);
    if (cur == '0) return rel;
    return cur - 1'b1;
  endfunction

  tmr_prescaler u_pre (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run),
    .psel (psel_q),
    .tick (tick)
  );

  assign underflow  = tick && (count_q == '0);
  assign flag_clear = wr_ctrl && !wdata[CTRL_UF_BIT];
  assign count_nxt  = step_count(count_q, const_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count_q <= '1;
    else if (wr_count) count_q <= wdata;
    else if (tick)     count_q <= count_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        const_q <= '1;
    else if (wr_const) const_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psel_q <= '0;
      ie_q   <= 1'b0;
    end else if (wr_ctrl) begin
      psel_q <= wdata[CTRL_PSEL_LSB +: CTRL_PSEL_W];
      ie_q   <= wdata[CTRL_IE_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          uf_q <= 1'b0;
    else if (underflow)  uf_q <= 1'b1;
    else if (flag_clear) uf_q <= 1'b0;
  end

  always_comb begin
    ctrl_rd = '0;
    ctrl_rd[CTRL_PSEL_LSB +: CTRL_PSEL_W] = psel_q;
    ctrl_rd[CTRL_IE_BIT] = ie_q;
    ctrl_rd[CTRL_UF_BIT] = uf_q;
  end

  assign irq = uf_q && ie_q;

  // R3
  decrement_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && count_q != '0 && !wr_count) |=> count_q == DATA_W'($past(count_q) - 1'b1));
  // R4
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && count_q == '0 && !wr_count) |=> (count_q == $past(const_q)) && uf_q);
  // R7
  frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_count) |=> $stable(count_q));
  // R6
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !flag_clear) |=> uf_q == $past(uf_q));
endmodule

// File: rtl/tick_timer_unit.sv
module tick_timer_unit
  import tmr_pkg::*;
#(
  parameter int unsigned NUM_CH = 3,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [NUM_CH-1:0] irq
);
  localparam int unsigned WORD_W   = ADDR_W - 2;
  localparam int unsigned REGS_PER = 3;

  logic [NUM_CH-1:0] run_q;
  logic              aligned;
  logic [WORD_W-1:0] word;
  logic              hit_start;
  logic [NUM_CH-1:0] sel_const, sel_count, sel_ctrl;
  logic [DATA_W-1:0] const_v [NUM_CH];
  logic [DATA_W-1:0] count_v [NUM_CH];
  logic [DATA_W-1:0] ctrl_v  [NUM_CH];

  assign aligned   = (addr[1:0] == 2'b00);
  assign word      = addr[ADDR_W-1:2];
  assign hit_start = aligned && (word == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  run_q <= '0;
    else if (wr_en && hit_start) run_q <= wdata[NUM_CH-1:0];
  end

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    localparam int unsigned BASE = 1 + REGS_PER * n;
    assign sel_const[n] = aligned && (word == WORD_W'(BASE));
    assign sel_count[n] = aligned && (word == WORD_W'(BASE + 1));
    assign sel_ctrl[n]  = aligned && (word == WORD_W'(BASE + 2));

    tmr_channel #(.DATA_W(DATA_W)) u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run_q[n]),
      .wr_const(wr_en && sel_const[n]),
      .wr_count(wr_en && sel_count[n]),
      .wr_ctrl (wr_en && sel_ctrl[n]),
      .wdata   (wdata),
      .const_q (const_v[n]),
      .count_q (count_v[n]),
      .ctrl_rd (ctrl_v[n]),
      .irq     (irq[n])
    );
  end

  always_comb begin
    rdata = '0;
    if (hit_start) rdata[NUM_CH-1:0] = run_q;
    for (int n = 0; n < NUM_CH; n++) begin
      if (sel_const[n]) rdata = const_v[n];
      if (sel_count[n]) rdata = count_v[n];
      if (sel_ctrl[n])  rdata = ctrl_v[n];
    end
  end

  // R9
  one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({hit_start, sel_const, sel_count, sel_ctrl}) <= 1);
  // R2
  start_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hit_start) |=> run_q == $past(wdata[NUM_CH-1:0]));
endmodule

// File: tb/tb_tick_timer_unit.sv
`timescale 1ns/1ps
module tb_tick_timer_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [2:0]  irq;
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tick_timer_unit dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
    .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  function automatic logic [5:0] a_const(int ch); return 6'(4 + 12*ch);  endfunction
  function automatic logic [5:0] a_count(int ch); return 6'(8 + 12*ch);  endfunction
  function automatic logic [5:0] a_ctrl(int ch);  return 6'(12 + 12*ch); endfunction
  function automatic int divisor(int code);
    if (code == 1) return 16;
    if (code == 2) return 64;
    if (code == 3) return 256;
    return 4;
  endfunction
  // counter after t ticks starting from c with reload k
  function automatic logic [31:0] model_count(longint c, longint k, longint t);
    longint tp;
    if (t <= c) return 32'(c - t);
    tp = t - c - 1;
    return 32'(k - (tp % (k + 1)));
  endfunction

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk); #1; wr_en = 1'b0;
  endtask
  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask
  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask
  // run the channels in mask for exactly n clock edges (n >= 1)
  task automatic run_seg(input logic [2:0] mask, input int n);
    wr(6'd0, {29'd0, mask});
    repeat (n - 1) @(posedge clk);
    wr(6'd0, 32'd0);
  endtask
  task automatic summary;
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    end
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] v;
    int codes [6] = '{0, 1, 2, 3, 5, 7};
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    rd(6'd0, v); check("R1 start", v, 32'd0);
    for (int ch = 0; ch < 3; ch++) begin
      rd(a_const(ch), v); check("R1 const", v, 32'hFFFF_FFFF);
      rd(a_count(ch), v); check("R1 count", v, 32'hFFFF_FFFF);
      rd(a_ctrl(ch), v);  check("R1 ctrl", v, 32'd0);
    end
    check("R1 irq", {29'd0, irq}, 32'd0);

    // R9 unmapped offsets: writes ignored, reads zero
    wr(6'd1, 32'hFFFF_FFFF);
    wr(6'd6, 32'h1234_5678);
    wr(6'h28, 32'hFFFF_FFFF);
    wr(6'h3C, 32'hFFFF_FFFF);
    rd(6'd0, v);  check("R9 start untouched", v, 32'd0);
    rd(6'd4, v);  check("R9 const0 untouched", v, 32'hFFFF_FFFF);
    rd(6'd8, v);  check("R9 count0 untouched", v, 32'hFFFF_FFFF);
    rd(6'd1, v);  check("R9 read misaligned", v, 32'd0);
    rd(6'h28, v); check("R9 read beyond", v, 32'd0);
    rd(6'h3C, v); check("R9 read top", v, 32'd0);

    // R2 address map readback
    for (int ch = 0; ch < 3; ch++) begin
      wr(a_const(ch), 32'hA000_0000 + ch);
      wr(a_count(ch), 32'hB000_0000 + ch);
      wr(a_ctrl(ch), 32'(ch + 1));
    end
    for (int ch = 0; ch < 3; ch++) begin
      rd(a_const(ch), v); check("R2 const map", v, 32'hA000_0000 + ch);
      rd(a_count(ch), v); check("R2 count map", v, 32'hB000_0000 + ch);
      rd(a_ctrl(ch), v);  check("R2 ctrl map", v, 32'(ch + 1));
    end
    wr(6'd0, 32'd0); rd(6'd0, v); check("R2 start read", v, 32'd0);

    // R3 R4 R5 sweep over channels and prescaler codes
    for (int ch = 0; ch < 3; ch++) begin
      for (int i = 0; i < 6; i++) begin
        int code = codes[i];
        int ie = i % 2;
        int t = i + ch + 1;
        int nedge = t * divisor(code) + ch;
        logic [31:0] ec;
        logic flag;
        wr(a_ctrl(ch), 32'((ie << 5) | code));
        wr(a_const(ch), 32'd2);
        wr(a_count(ch), 32'd4);
        run_seg(3'(1 << ch), nedge);
        ec = model_count(4, 2, t);
        flag = (t > 4);
        rd(a_count(ch), v); check("R3 R4 count", v, ec);
        rd(a_ctrl(ch), v);  check("R4 ctrl flag", v, 32'((int'(flag) << 8) | (ie << 5) | code));
        check("R5 irq", {31'd0, irq[ch]}, {31'd0, flag && (ie == 1)});
      end
    end

    // R6 flag clear and write-one no effect
    wr(a_ctrl(0), 32'h20); wr(a_const(0), 32'd5); wr(a_count(0), 32'd0);
    run_seg(3'b001, 4);
    rd(a_count(0), v); check("R4 reload from zero", v, 32'd5);
    wr(a_ctrl(0), 32'h121);
    rd(a_ctrl(0), v); check("R6 write one keeps flag", v, 32'h121);
    check("R6 irq kept", {29'd0, irq} & 32'd1, 32'd1);
    wr(a_ctrl(0), 32'h020);
    rd(a_ctrl(0), v); check("R6 write zero clears", v, 32'h020);
    check("R6 irq cleared", {29'd0, irq} & 32'd1, 32'd0);

    // R7 stop freezes, restart resumes with fresh phase
    wr(a_ctrl(1), 32'd0); wr(a_const(1), 32'd100); wr(a_count(1), 32'd100);
    run_seg(3'b010, 10);
    rd(a_count(1), v); check("R7 after first segment", v, 32'd98);
    repeat (50) @(posedge clk);
    rd(a_count(1), v); check("R7 frozen while stopped", v, 32'd98);
    run_seg(3'b010, 7);
    rd(a_count(1), v); check("R7 resumed phase reset", v, 32'd97);

    // R8 counter write while running overrides same-edge tick
    wr(a_ctrl(2), 32'd0); wr(a_const(2), 32'd1000); wr(a_count(2), 32'd500);
    wr(6'd0, 32'd4);
    repeat (7) @(posedge clk);
    wr(a_count(2), 32'd300);
    repeat (3) @(posedge clk);
    wr(6'd0, 32'd0);
    rd(a_count(2), v); check("R8 live write", v, 32'd299);

    // R10 three channels at once, different ratios
    for (int ch = 0; ch < 3; ch++) begin
      wr(a_ctrl(ch), 32'(ch)); wr(a_const(ch), 32'd1000); wr(a_count(ch), 32'd1000);
    end
    run_seg(3'b111, 300);
    rd(a_count(0), v); check("R10 ch0 /4", v, 32'd925);
    rd(a_count(1), v); check("R10 ch1 /16", v, 32'd982);
    rd(a_count(2), v); check("R10 ch2 /64", v, 32'd996);
    wr(6'd0, 32'd5); rd(6'd0, v); check("R2 start bits", v, 32'd5);
    wr(6'd0, 32'd0);

    summary();
    $finish;
  end
endmodule